// File: doc/BRIEF.md
# Banked Register File for an 8-bit Processor

This block is the register storage of a small 8-bit processor core. It holds an accumulator A and a flag byte F, six general bytes (B, C, D, E, H, L) that also pair up as BC, DE and HL, and a complete alternate copy of all eight. It also holds two 16-bit index registers (IX, IY) with byte-level access, an interrupt-vector byte I and a refresh counter byte R. Instruction decode, the ALU and bus sequencing live elsewhere. The core drives select codes, write enables and command strobes, and reads results back on two read ports: one byte wide and one pair wide.

Two exchange strobes switch between the main and alternate sets. One switches only A/F. The other switches BC, DE and HL together. Each exchange toggles a bank-select flip-flop, so no data moves. Reads always see the active bank, and the alternate A/F can be reached only through its exchange strobe. A fetch strobe steps the low seven bits of R once per opcode or prefix-byte fetch, so external logic can use R as a dynamic-memory refresh address.

Top module: `cpu_regbank`

## Requirements
- R1: Byte codes 0..7 select A, F, B, C, D, E, H, L. A write (`wr_en`, `wr_sel`, `wr_data`) lands on the rising clock edge. `rd_data` shows the selected byte of the active bank combinationally.
- R2: Pair codes 0, 1, 2, 3 select BC, DE, HL, AF. The first-named register is the high byte, bits 15:8. A pair write updates both bytes on one edge, and `prd_data` reads both.
- R3: Byte codes 8, 9, 10, 11 select IXH, IXL, IYH, IYL, and pair codes 4 and 5 select IX and IY. Neither exchange strobe changes them.
- R4: Byte code 12 selects the interrupt-vector byte I and byte code 13 selects the refresh byte R. Both can be read and written like any other byte.
- R5: `xchg_af` swaps A and F with their alternates and leaves B through L unchanged. Applying it twice restores the original view.
- R6: `xchg_all` swaps B, C, D, E, H and L with their alternates in one cycle and leaves A and F unchanged. Both strobes together perform both swaps.
- R7: A byte or pair write in the same cycle as an exchange goes to the bank that was active before that exchange.
- R8: `fetch_stb` adds one to R bits 6:0 with wrap from 0x7F to 0x00, and R bit 7 keeps its written value. A write to R in the same cycle takes priority over the increment.
- R9: Reset (`rst_n` low, asynchronous) zeroes every byte in both banks, including I and R, and makes the main banks active.
- R10: When a byte write and a pair write hit the same byte in one cycle, the byte write wins. Byte codes 14 and 15 and pair codes 6 and 7 read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_sel | input | 4 | Byte read select code |
| rd_data | output | 8 | Selected byte, active bank |
| prd_sel | input | 3 | Pair read select code |
| prd_data | output | 16 | Selected pair, high byte first-named |
| wr_en | input | 1 | Byte write enable |
| wr_sel | input | 4 | Byte write select code |
| wr_data | input | 8 | Byte write data |
| pwr_en | input | 1 | Pair write enable |
| pwr_sel | input | 3 | Pair write select code |
| pwr_data | input | 16 | Pair write data |
| xchg_af | input | 1 | Swap A/F with alternates |
| xchg_all | input | 1 | Swap BC, DE, HL with alternates |
| fetch_stb | input | 1 | Opcode or prefix fetch, steps R |

## Verification
Directed patterns come first. Distinct byte values are written into each register, so a swapped pair half or a wrong byte code reads back wrong. An exchange is issued alone, then twice, then together with the other exchange and with a write in the same cycle; these steps separate a data-copying swap, a wrong subset and a write landing in the wrong bank. R is loaded with 0x7F and 0xFF and then fetched, which shows whether bit 7 is held across the wrap. A long pseudo-random phase mixes overlapping byte and pair writes, reserved codes, exchanges and fetches, and compares against a value-swapping reference model every cycle.

// File: rtl/rb_pkg.sv
package rb_pkg;
   localparam int NUM_BYTES = 14;
   localparam int SEL_W     = 4;
   localparam int PSEL_W    = 3;

   // byte slot numbers
   localparam int SL_A    = 0;
   localparam int SL_F    = 1;
   localparam int SL_B    = 2;
   localparam int SL_L    = 7;
   localparam int SL_IXH  = 8;
   localparam int SL_IVEC = 12;
   localparam int SL_RFSH = 13;

   localparam int AF_CNT    = SL_F - SL_A + 1;
   localparam int MAIN_CNT  = SL_L - SL_B + 1;
   localparam int PLAIN_CNT = SL_IVEC - SL_IXH + 1;

   // slot of the high byte of a pair code, -1 when the code is unused
   function automatic int pair_hi(input logic [PSEL_W-1:0] code);
      case (code)
         3'd0:    return 2;
         3'd1:    return 4;
         3'd2:    return 6;
         3'd3:    return 0;
         3'd4:    return 8;
         3'd5:    return 10;
         default: return -1;
      endcase
   endfunction
endpackage

// File: rtl/rb_wr_decode.sv
module rb_wr_decode
   import rb_pkg::*;
#(
   parameter int DW = 8,
   parameter int NB = NUM_BYTES
) (
   input  logic                       wr_en,
   input  logic [SEL_W-1:0]           wr_sel,
   input  logic [DW-1:0]              wr_data,
   input  logic                       pwr_en,
   input  logic [PSEL_W-1:0]          pwr_sel,
   input  logic [2*DW-1:0]            pwr_data,
   output logic [NB-1:0]              byte_we,
   output logic [NB-1:0][DW-1:0]      byte_wd
);
   int hi;

   always_comb begin
      hi      = pair_hi(pwr_sel);
      byte_we = '0;
      byte_wd = '0;
      for (int k = 0; k < NB; k++) begin
         if (pwr_en && hi >= 0 && k == hi) begin
            byte_we[k] = 1'b1;
            byte_wd[k] = pwr_data[2*DW-1:DW];
         end
         if (pwr_en && hi >= 0 && k == hi + 1) begin
            byte_we[k] = 1'b1;
            byte_wd[k] = pwr_data[DW-1:0];
         end
         // byte port overrides pair port on the same slot
         if (wr_en && int'(wr_sel) == k) begin
            byte_we[k] = 1'b1;
            byte_wd[k] = wr_data;
         end
      end
   end
endmodule

// File: rtl/rb_banked_set.sv
module rb_banked_set #(
   parameter int N  = 2,
   parameter int DW = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  swap,
   input  logic [N-1:0]          we,
   input  logic [N-1:0][DW-1:0]  wd,
   output logic [N-1:0][DW-1:0]  q
);
   logic [N-1:0][DW-1:0] bank0;
   logic [N-1:0][DW-1:0] bank1;
   logic                 use_alt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         use_alt <= 1'b0;
         bank0   <= '0;
         bank1   <= '0;
      end else begin
         if (swap) use_alt <= ~use_alt;
         for (int i = 0; i < N; i++) begin
            if (we[i]) begin
               // bank chosen by the pre-swap select
               if (use_alt) bank1[i] <= wd[i];
               else         bank0[i] <= wd[i];
            end
         end
      end
   end

   always_comb begin
      for (int i = 0; i < N; i++) q[i] = use_alt ? bank1[i] : bank0[i];
   end
endmodule

// File: rtl/rb_plain_set.sv
module rb_plain_set #(
   parameter int N  = 5,
   parameter int DW = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [N-1:0]          we,
   input  logic [N-1:0][DW-1:0]  wd,
   output logic [N-1:0][DW-1:0]  q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else begin
         for (int i = 0; i < N; i++) if (we[i]) q[i] <= wd[i];
      end
   end
endmodule

// File: rtl/rb_refresh.sv
module rb_refresh #(
   parameter int DW     = 8,
   parameter int RCNT_W = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [DW-1:0] wd,
   input  logic          inc,
   output logic [DW-1:0] q
);
   localparam logic [RCNT_W-1:0] ONE = RCNT_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= '0;
      else if (we)  q <= wd;
      else if (inc) q[RCNT_W-1:0] <= q[RCNT_W-1:0] + ONE;
   end
endmodule

// File: rtl/cpu_regbank.sv
module cpu_regbank
   import rb_pkg::*;
#(
   parameter int DW     = 8,
   parameter int RCNT_W = 7
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [SEL_W-1:0]    rd_sel,
   output logic [DW-1:0]       rd_data,
   input  logic [PSEL_W-1:0]   prd_sel,
   output logic [2*DW-1:0]     prd_data,
   input  logic                wr_en,
   input  logic [SEL_W-1:0]    wr_sel,
   input  logic [DW-1:0]       wr_data,
   input  logic                pwr_en,
   input  logic [PSEL_W-1:0]   pwr_sel,
   input  logic [2*DW-1:0]     pwr_data,
   input  logic                xchg_af,
   input  logic                xchg_all,
   input  logic                fetch_stb
);
   localparam int NB = NUM_BYTES;

   if (DW < 2) begin : g_bad_dw
      $error("cpu_regbank: DW must be at least 2");
   end
   if (RCNT_W < 1 || RCNT_W > DW) begin : g_bad_rcnt
      $error("cpu_regbank: RCNT_W must lie in 1..DW");
   end

   logic [NB-1:0]          byte_we;
   logic [NB-1:0][DW-1:0]  byte_wd;
   wire  [NB-1:0][DW-1:0]  byte_q;
   int                     rd_hi;

   rb_wr_decode #(.DW(DW), .NB(NB)) u_dec (
      .wr_en   (wr_en),
      .wr_sel  (wr_sel),
      .wr_data (wr_data),
      .pwr_en  (pwr_en),
      .pwr_sel (pwr_sel),
      .pwr_data(pwr_data),
      .byte_we (byte_we),
      .byte_wd (byte_wd)
   );

   rb_banked_set #(.N(AF_CNT), .DW(DW)) u_af (
      .clk  (clk),
      .rst_n(rst_n),
      .swap (xchg_af),
      .we   (byte_we[SL_F:SL_A]),
      .wd   (byte_wd[SL_F:SL_A]),
      .q    (byte_q[SL_F:SL_A])
   );

   rb_banked_set #(.N(MAIN_CNT), .DW(DW)) u_main (
      .clk  (clk),
      .rst_n(rst_n),
      .swap (xchg_all),
      .we   (byte_we[SL_L:SL_B]),
      .wd   (byte_wd[SL_L:SL_B]),
      .q    (byte_q[SL_L:SL_B])
   );

   rb_plain_set #(.N(PLAIN_CNT), .DW(DW)) u_plain (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (byte_we[SL_IVEC:SL_IXH]),
      .wd   (byte_wd[SL_IVEC:SL_IXH]),
      .q    (byte_q[SL_IVEC:SL_IXH])
   );

   rb_refresh #(.DW(DW), .RCNT_W(RCNT_W)) u_rfsh (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (byte_we[SL_RFSH]),
      .wd   (byte_wd[SL_RFSH]),
      .inc  (fetch_stb),
      .q    (byte_q[SL_RFSH])
   );

   always_comb begin
      rd_data = '0;
      for (int k = 0; k < NB; k++) if (int'(rd_sel) == k) rd_data = byte_q[k];
   end

   always_comb begin
      rd_hi    = pair_hi(prd_sel);
      prd_data = '0;
      for (int k = 0; k < NB; k++) begin
         if (rd_hi >= 0 && k == rd_hi)     prd_data[2*DW-1:DW] = byte_q[k];
         if (rd_hi >= 0 && k == rd_hi + 1) prd_data[DW-1:0]    = byte_q[k];
      end
   end
endmodule

// File: rtl/rb_checker.sv
module rb_checker
   import rb_pkg::*;
#(
   parameter int DW     = 8,
   parameter int RCNT_W = 7,
   parameter int NB     = NUM_BYTES
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  fetch_stb,
   input logic                  xchg_af,
   input logic                  xchg_all,
   input logic [NB-1:0]         byte_we,
   input logic [NB-1:0][DW-1:0] byte_q
);
   // R3: index bytes move only on a write, never on an exchange
   p_index_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      byte_we[SL_IVEC-1:SL_IXH] == '0 |=> $stable(byte_q[SL_IVEC-1:SL_IXH]));

   // R4: vector byte holds without a write
   p_ivec_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !byte_we[SL_IVEC] |=> $stable(byte_q[SL_IVEC]));

   // R5: A/F exchange leaves the main group alone
   p_af_swap_scope_r5: assert property (@(posedge clk) disable iff (!rst_n)
      xchg_af && !xchg_all && byte_we[SL_L:SL_B] == '0 |=> $stable(byte_q[SL_L:SL_B]));

   // R6: group exchange leaves A/F alone
   p_all_swap_scope_r6: assert property (@(posedge clk) disable iff (!rst_n)
      xchg_all && !xchg_af && byte_we[SL_F:SL_A] == '0 |=> $stable(byte_q[SL_F:SL_A]));

   // R8: fetch steps the low field of R by one
   p_rfsh_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_stb && !byte_we[SL_RFSH] |=>
         byte_q[SL_RFSH][RCNT_W-1:0] == RCNT_W'($past(byte_q[SL_RFSH][RCNT_W-1:0]) + 1'b1));

   if (RCNT_W < DW) begin : g_msb
      // R8: upper bits of R never count
      p_rfsh_msb_r8: assert property (@(posedge clk) disable iff (!rst_n)
         !byte_we[SL_RFSH] |=> $stable(byte_q[SL_RFSH][DW-1:RCNT_W]));
   end

   // R9: vector and refresh bytes leave reset at zero
   p_reset_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> byte_q[SL_IVEC] == '0 && byte_q[SL_RFSH] == '0);
endmodule

bind cpu_regbank rb_checker #(.DW(DW), .RCNT_W(RCNT_W), .NB(rb_pkg::NUM_BYTES)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .fetch_stb(fetch_stb),
   .xchg_af  (xchg_af),
   .xchg_all (xchg_all),
   .byte_we  (byte_we),
   .byte_q   (byte_q)
);

// File: tb/cpu_regbank_tb_top.sv
module cpu_regbank_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  rd_sel = '0;
   logic [7:0]  rd_data;
   logic [2:0]  prd_sel = '0;
   logic [15:0] prd_data;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_sel = '0;
   logic [7:0]  wr_data = '0;
   logic        pwr_en = 1'b0;
   logic [2:0]  pwr_sel = '0;
   logic [15:0] pwr_data = '0;
   logic        xchg_af = 1'b0;
   logic        xchg_all = 1'b0;
   logic        fetch_stb = 1'b0;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // reference state: active view plus alternate copies, swapped by value
   logic [7:0] m_act [14];
   logic [7:0] m_alt [8];

   always #5 clk = ~clk;

   cpu_regbank dut_i (
      .clk(clk), .rst_n(rst_n),
      .rd_sel(rd_sel), .rd_data(rd_data),
      .prd_sel(prd_sel), .prd_data(prd_data),
      .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .pwr_en(pwr_en), .pwr_sel(pwr_sel), .pwr_data(pwr_data),
      .xchg_af(xchg_af), .xchg_all(xchg_all), .fetch_stb(fetch_stb)
   );

   function automatic int hi_of(int p);
      case (p)
         0: return 2;
         1: return 4;
         2: return 6;
         3: return 0;
         4: return 8;
         5: return 10;
         default: return -1;
      endcase
   endfunction

   function automatic logic [7:0] m_byte(int s);
      if (s < 14) return m_act[s];
      return 8'h00;
   endfunction

   function automatic logic [15:0] m_pair(int p);
      int h = hi_of(p);
      if (h < 0) return 16'h0000;
      return {m_act[h], m_act[h+1]};
   endfunction

   function automatic string byte_tag(int s);
      if (s < 8)  return "R1";
      if (s < 12) return "R3";
      if (s < 14) return "R4";
      return "R10";
   endfunction

   function automatic string pair_tag(int p);
      if (p < 4) return "R2";
      if (p < 6) return "R3";
      return "R10";
   endfunction

   task automatic model_reset();
      foreach (m_act[k]) m_act[k] = 8'h00;
      foreach (m_alt[k]) m_alt[k] = 8'h00;
   endtask

   task automatic model_clock();
      logic [7:0] nxt [14];
      logic [7:0] t;
      int h;
      bit r_written = 1'b0;
      nxt = m_act;
      h = hi_of(int'(pwr_sel));
      if (pwr_en && h >= 0) begin
         nxt[h] = pwr_data[15:8];
         nxt[h+1] = pwr_data[7:0];
         if (h + 1 == 13 || h == 13) r_written = 1'b1;
      end
      if (wr_en && wr_sel < 4'd14) begin
         nxt[wr_sel] = wr_data;
         if (wr_sel == 4'd13) r_written = 1'b1;
      end
      if (fetch_stb && !r_written)
         nxt[13] = {m_act[13][7], 7'(m_act[13][6:0] + 7'd1)};
      if (xchg_af)
         for (int k = 0; k < 2; k++) begin t = nxt[k]; nxt[k] = m_alt[k]; m_alt[k] = t; end
      if (xchg_all)
         for (int k = 2; k < 8; k++) begin t = nxt[k]; nxt[k] = m_alt[k]; m_alt[k] = t; end
      m_act = nxt;
   endtask

   task automatic chk(string tag, logic [15:0] act_v, logic [15:0] exp_v);
      checks++;
      if (act_v !== exp_v) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act_v, exp_v);
      end
   endtask

   task automatic idle();
      wr_en = 1'b0; pwr_en = 1'b0; xchg_af = 1'b0; xchg_all = 1'b0; fetch_stb = 1'b0;
   endtask

   // compare both read ports against the model, then advance one clock
   task automatic cyc(string tag);
      #1;
      chk({tag, "/", byte_tag(int'(rd_sel))}, {8'h00, rd_data}, {8'h00, m_byte(int'(rd_sel))});
      chk({tag, "/", pair_tag(int'(prd_sel))}, prd_data, m_pair(int'(prd_sel)));
      @(posedge clk);
      if (rst_n) model_clock(); else model_reset();
      @(negedge clk);
      idle();
   endtask

   task automatic wbyte(int s, logic [7:0] v);
      wr_en = 1'b1; wr_sel = 4'(s); wr_data = v;
   endtask

   task automatic wpair(int p, logic [15:0] v);
      pwr_en = 1'b1; pwr_sel = 3'(p); pwr_data = v;
   endtask

   // fixed-value check, independent of the model
   task automatic expect_const(string tag, int s, int p, logic [7:0] eb, logic [15:0] ep);
      rd_sel = 4'(s); prd_sel = 3'(p);
      #1;
      chk(tag, {8'h00, rd_data}, {8'h00, eb});
      chk(tag, prd_data, ep);
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual running expected finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      model_reset();
      @(negedge clk); @(negedge clk); @(negedge clk);
      // R9: reset state
      for (int s = 0; s < 16; s++) expect_const("R9 reset", s, s % 8, 8'h00, 16'h0000);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: fill main bytes with distinct values
      for (int s = 0; s < 8; s++) begin wbyte(s, 8'(8'h10 + 8'h11 * s)); cyc("R1"); end
      expect_const("R1 byte C", 3, 0, 8'h43, 16'h3243);
      expect_const("R2 pair AF", 0, 3, 8'h10, 16'h1021);
      // R2: pair write then byte reads
      wpair(2, 16'hBEEF); cyc("R2");
      expect_const("R2 HL high", 6, 2, 8'hBE, 16'hBEEF);
      expect_const("R2 HL low", 7, 1, 8'hEF, 16'h5465);
      // R3: index registers
      wpair(4, 16'h1234); cyc("R3");
      wbyte(11, 8'hA5); cyc("R3");
      wbyte(10, 8'h5A); cyc("R3");
      expect_const("R3 IXH", 8, 5, 8'h12, 16'h5AA5);
      // R4: vector byte
      wbyte(12, 8'h3C); cyc("R4");
      expect_const("R4 I", 12, 4, 8'h3C, 16'h1234);
      // R5: A/F exchange shows zeroed alternates, main untouched
      xchg_af = 1'b1; cyc("R5");
      expect_const("R5 A alt", 0, 0, 8'h00, 16'h3243);
      wbyte(0, 8'h99); cyc("R5");
      xchg_af = 1'b1; cyc("R5");
      expect_const("R5 A back", 0, 3, 8'h10, 16'h1021);
      // R6: group exchange
      xchg_all = 1'b1; cyc("R6");
      expect_const("R6 alt BC", 2, 3, 8'h00, 16'h1021);
      expect_const("R6 IX kept", 9, 4, 8'h34, 16'h1234);
      xchg_all = 1'b1; cyc("R6");
      expect_const("R6 back HL", 6, 2, 8'hBE, 16'hBEEF);
      // R7: write together with exchange lands in the old bank
      wbyte(2, 8'h77); xchg_all = 1'b1; cyc("R7");
      expect_const("R7 new view", 2, 0, 8'h00, 16'h0000);
      xchg_all = 1'b1; cyc("R7");
      expect_const("R7 old bank", 2, 0, 8'h77, 16'h7743);
      wpair(3, 16'hC3D4); xchg_af = 1'b1; xchg_all = 1'b1; cyc("R7");
      xchg_af = 1'b1; cyc("R7");
      expect_const("R7 AF old bank", 1, 3, 8'hD4, 16'hC3D4);
      // R8: refresh counting
      wbyte(13, 8'h7F); cyc("R8");
      fetch_stb = 1'b1; cyc("R8");
      expect_const("R8 wrap low", 13, 0, 8'h00, m_pair(0));
      wbyte(13, 8'hFF); cyc("R8");
      fetch_stb = 1'b1; cyc("R8");
      fetch_stb = 1'b1; cyc("R8");
      expect_const("R8 msb held", 13, 0, 8'h81, m_pair(0));
      wbyte(13, 8'h40); fetch_stb = 1'b1; cyc("R8");
      expect_const("R8 write wins", 13, 0, 8'h40, m_pair(0));
      // R10: overlap and reserved codes
      wpair(1, 16'h1122); wbyte(5, 8'hEE); cyc("R10");
      expect_const("R10 byte wins", 14, 1, 8'h00, 16'h11EE);
      wbyte(15, 8'hAB); wpair(7, 16'hFFFF); cyc("R10");
      expect_const("R10 reserved", 15, 6, 8'h00, 16'h0000);
      expect_const("R10 nothing hit", 4, 1, 8'h11, 16'h11EE);

      // random phase
      for (int n = 0; n < 4000; n++) begin
         rd_sel    = 4'($urandom_range(0, 15));
         prd_sel   = 3'($urandom_range(0, 7));
         wr_en     = ($urandom_range(0, 2) == 0);
         wr_sel    = 4'($urandom_range(0, 15));
         wr_data   = 8'($urandom);
         pwr_en    = ($urandom_range(0, 3) == 0);
         pwr_sel   = 3'($urandom_range(0, 7));
         pwr_data  = 16'($urandom);
         xchg_af   = ($urandom_range(0, 7) == 0);
         xchg_all  = ($urandom_range(0, 7) == 0);
         fetch_stb = ($urandom_range(0, 1) == 0);
         if (n == 2000) begin
            idle();
            rst_n = 1'b0;
            model_reset();
            cyc("R9"); cyc("R9");
            rst_n = 1'b1;
         end
         cyc("RND");
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule